// File: doc/BRIEF.md
# Sampling Tap Window Selector

This block turns the raw results of a receive-timing tuning sweep into a single sampling tap. The tuning logic elsewhere probes every tap of a delay line twice, in two full passes, and hands over two masks with one bit per probe. The pass mask marks probes that completed without error. The compare mask marks probes whose sampled data matched. Probe number i targets tap i mod N.

On a start pulse, the block folds each mask so that a tap counts as good only when both of its probes succeeded. It then walks the folded masks one bit per clock and tracks the longest unbroken run of good probes. It picks the middle of that run and maps it back onto a tap number. When every probe passed, the pass mask says nothing about where the eye is, so the decision moves to the compare mask. A short pass window is rejected. A successful selection also arms automatic re-tuning.

The result stays on registered outputs until the next start. After a failed selection the previous tap is left in place.

Top module: `tap_window_selector`

## Requirements
- R1: Folding is applied to both masks. Probe bits are numbered 0 to 2N-1, with probe i on tap i mod N. A 0 in bit i of a mask clears bit (i mod N) and bit (i mod N)+N of that same mask before any run is measured.
- R2: The block measures the longest run of consecutive 1s in the folded pass mask over bits 0 to 2N-1. A run that ends at bit 2N-1 counts. Among runs of equal length, the lowest-starting one is kept.
- R3: If the pass run spans all 2N bits, the run is measured again on the folded compare mask, and that run decides. Selection fails if that run is empty.
- R4: If the pass run is shorter than 2N bits, selection succeeds only when it is at least 3 bits long.
- R5: On success, sel_tap is ((first + last) / 2) mod N, where first and last are the end bits of the deciding run and the division rounds down.
- R6: On failure, sel_error is 1, sel_valid is 0, retune_en is 0, and sel_tap keeps its previous value.
- R7: On success, sel_valid and retune_en are 1 and sel_error is 0. In the cycle after start is accepted, sel_valid, sel_error and retune_en are 0 and retune_clr pulses 1 for one cycle.
- R8: A tap_count of 0, or one above MAX_TAPS, means tuning is unsupported. done then pulses one cycle after start, with sel_valid and sel_error both 0 and sel_tap unchanged.
- R9: For a supported tap_count N, done is a one-cycle pulse that is visible 2N+1 clock cycles after the edge that accepted start. busy is 1 from the accepting edge until done.
- R10: Mask bits at position 2N and above have no effect on the result.
- R11: After reset, busy, done, sel_valid, sel_error, retune_en and retune_clr are 0 and sel_tap is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a selection (accepted when not busy) |
| tap_count | input | $clog2(MAX_TAPS+1) | Number of taps N for this sweep |
| pass_mask | input | 2*MAX_TAPS | Per-probe success bits |
| cmp_mask | input | 2*MAX_TAPS | Per-probe data-match bits |
| busy | output | 1 | Selection in progress |
| done | output | 1 | One-cycle completion pulse |
| sel_valid | output | 1 | Last selection succeeded |
| sel_error | output | 1 | Last selection failed |
| sel_tap | output | $clog2(MAX_TAPS) | Selected tap index |
| retune_en | output | 1 | Automatic re-tuning armed |
| retune_clr | output | 1 | Pulse clearing re-tune request/error status |

## Verification
The bench builds the block with MAX_TAPS = 4, so the masks are 8 bits wide. At that size, every pass mask can be applied for every tap count from 1 to 4, and every compare mask can be applied under an all-pass sweep. This reaches every tie, every run that touches the top bit, and every window length around the minimum of 3. Tap counts of 0, 5 and 7 cover the unsupported path. Extra runs with the bits above 2N set show that those bits are ignored, and the tap held across failures is tracked in the bench.

// File: rtl/tapsel_pkg.sv
package tapsel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_DECIDE = 2'd2
  } tapsel_state_e;
endpackage

// File: rtl/tapsel_fold.sv
// Cross-pass fold: a tap survives only if both of its probes are set.
module tapsel_fold #(
  parameter int MAX_TAPS = 8,
  localparam int W  = 2 * MAX_TAPS,
  localparam int CW = $clog2(MAX_TAPS + 1),
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [CW-1:0] n,
  input  logic [W-1:0]  raw,
  output logic [W-1:0]  folded
);
  always_comb begin
    for (int j = 0; j < W; j++) begin
      logic [IW-1:0] lo;
      logic [IW-1:0] hi;
      lo = '0;
      hi = '0;
      folded[j] = 1'b0;
      if (j < 2 * int'(n)) begin
        if (j < int'(n)) begin
          lo = IW'(j);
          hi = IW'(j + int'(n));
        end else begin
          lo = IW'(j - int'(n));
          hi = IW'(j);
        end
        folded[j] = raw[lo] & raw[hi];
      end
    end
  end
endmodule

// File: rtl/tapsel_run.sv
// Serial longest-run tracker; earliest run wins on ties.
module tapsel_run #(
  parameter int W = 16,
  localparam int IDXW = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            step,
  input  logic            bit_in,
  input  logic [IDXW-1:0] idx,
  output logic [IDXW-1:0] run_len,
  output logic [IDXW-1:0] run_start
);
  logic [IDXW-1:0] cur_len, best_len, best_start;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur_len    <= '0;
      best_len   <= '0;
      best_start <= '0;
    end else if (step) begin
      if (bit_in) begin
        cur_len <= cur_len + 1'b1;
      end else begin
        if (cur_len > best_len) begin
          best_len   <= cur_len;
          best_start <= idx - cur_len;
        end
        cur_len <= '0;
      end
    end
  end

  // Close a run still open at the scan position.
  always_comb begin
    if (cur_len > best_len) begin
      run_len   = cur_len;
      run_start = idx - cur_len;
    end else begin
      run_len   = best_len;
      run_start = best_start;
    end
  end

  AST_RUN_WITHIN_SCAN: assert property (@(posedge clk) disable iff (rst)
    (!clr && !step) |-> (run_len <= idx)); // R2
endmodule

// File: rtl/tap_window_selector.sv
module tap_window_selector #(
  parameter int MAX_TAPS = 8,
  parameter int MIN_RUN  = 3,
  localparam int W    = 2 * MAX_TAPS,
  localparam int CW   = $clog2(MAX_TAPS + 1),
  localparam int IDXW = $clog2(W + 1),
  localparam int TAPW = (MAX_TAPS > 1) ? $clog2(MAX_TAPS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [CW-1:0]   tap_count,
  input  logic [W-1:0]    pass_mask,
  input  logic [W-1:0]    cmp_mask,
  output logic            busy,
  output logic            done,
  output logic            sel_valid,
  output logic            sel_error,
  output logic [TAPW-1:0] sel_tap,
  output logic            retune_en,
  output logic            retune_clr
);
  import tapsel_pkg::*;

  tapsel_state_e   state;
  logic [CW-1:0]   n_q;
  logic            unsup_q;
  logic [IDXW-1:0] idx;
  logic [1:0][W-1:0] raw_pair, fold_pair, shift_q;
  logic [1:0][IDXW-1:0] len_pair, start_pair;
  logic            accept, step, clr;

  assign raw_pair = {cmp_mask, pass_mask};
  assign accept   = (state == ST_IDLE) && start;
  assign step     = (state == ST_SCAN);
  assign clr      = accept;

  // Index 0 handles the pass mask, index 1 the compare mask.
  for (genvar k = 0; k < 2; k++) begin : g_lane
    tapsel_fold #(.MAX_TAPS(MAX_TAPS)) u_fold (
      .n      (tap_count),
      .raw    (raw_pair[k]),
      .folded (fold_pair[k])
    );
    tapsel_run #(.W(W)) u_run (
      .clk       (clk),
      .rst       (rst),
      .clr       (clr),
      .step      (step),
      .bit_in    (shift_q[k][0]),
      .idx       (idx),
      .run_len   (len_pair[k]),
      .run_start (start_pair[k])
    );
  end

  // Decision logic evaluated in ST_DECIDE.
  logic [IDXW-1:0] two_n, use_len, use_start, mid, tap_full;
  logic [IDXW:0]   span_sum;
  logic            all_pass, pick_ok;

  always_comb begin
    two_n    = IDXW'({n_q, 1'b0});
    all_pass = (len_pair[0] == two_n);
    if (all_pass) begin
      use_len   = len_pair[1];
      use_start = start_pair[1];
      pick_ok   = (len_pair[1] != '0);
    end else begin
      use_len   = len_pair[0];
      use_start = start_pair[0];
      pick_ok   = (len_pair[0] >= IDXW'(MIN_RUN));
    end
    span_sum = (IDXW+1)'({use_start, 1'b0}) + (IDXW+1)'(use_len) - (IDXW+1)'(1);
    mid      = IDXW'(span_sum >> 1);
    tap_full = (mid >= IDXW'(n_q)) ? (mid - IDXW'(n_q)) : mid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      n_q        <= '0;
      unsup_q    <= 1'b0;
      idx        <= '0;
      shift_q    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      sel_valid  <= 1'b0;
      sel_error  <= 1'b0;
      sel_tap    <= '0;
      retune_en  <= 1'b0;
      retune_clr <= 1'b0;
    end else begin
      done       <= 1'b0;
      retune_clr <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            n_q        <= tap_count;
            unsup_q    <= (tap_count == '0) || (int'(tap_count) > MAX_TAPS);
            shift_q    <= fold_pair;
            idx        <= '0;
            busy       <= 1'b1;
            sel_valid  <= 1'b0;
            sel_error  <= 1'b0;
            retune_en  <= 1'b0;
            retune_clr <= 1'b1;
            state      <= ((tap_count == '0) || (int'(tap_count) > MAX_TAPS))
                          ? ST_DECIDE : ST_SCAN;
          end
        end
        ST_SCAN: begin
          shift_q[0] <= shift_q[0] >> 1;
          shift_q[1] <= shift_q[1] >> 1;
          idx        <= idx + 1'b1;
          if (idx + 1'b1 == two_n) state <= ST_DECIDE;
        end
        ST_DECIDE: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
          if (!unsup_q) begin
            if (pick_ok) begin
              sel_valid <= 1'b1;
              sel_tap   <= TAPW'(tap_full);
              retune_en <= 1'b1;
            end else begin
              sel_error <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(sel_valid && sel_error)); // R6
  AST_RETUNE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    retune_en |-> sel_valid); // R7
  AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (CW'(sel_tap) < n_q)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_TAP_KEPT_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
    (done && !sel_valid) |-> (sel_tap == $past(sel_tap))); // R6
endmodule

// File: tb/tb_tap_window_selector.sv
`timescale 1ns/1ps
module tb_tap_window_selector;
  localparam int MAXT = 4;
  localparam int W    = 2 * MAXT;
  localparam int CW   = $clog2(MAXT + 1);
  localparam int TAPW = $clog2(MAXT);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CW-1:0] tap_count = '0;
  logic [W-1:0] pass_mask = '0, cmp_mask = '0;
  logic busy, done, sel_valid, sel_error, retune_en, retune_clr;
  logic [TAPW-1:0] sel_tap;

  int nchk = 0, nfail = 0;
  int prev_tap = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  tap_window_selector #(.MAX_TAPS(MAXT), .MIN_RUN(3)) dut (
    .clk(clk), .rst(rst), .start(start), .tap_count(tap_count),
    .pass_mask(pass_mask), .cmp_mask(cmp_mask), .busy(busy), .done(done),
    .sel_valid(sel_valid), .sel_error(sel_error), .sel_tap(sel_tap),
    .retune_en(retune_en), .retune_clr(retune_clr));

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void longest(input logic [W-1:0] m, input int n,
                                  output int len, output int st);
    int cur = 0;
    len = 0; st = 0;
    for (int i = 0; i < 2 * n; i++) begin
      if (m[i]) cur++;
      else begin
        if (cur > len) begin len = cur; st = i - cur; end
        cur = 0;
      end
    end
    if (cur > len) begin len = cur; st = 2 * n - cur; end
  endfunction

  // Reference: literal in-place fold, then run search and decision.
  function automatic void model(input int n, input logic [W-1:0] p, c,
                                output bit ok, output int tap, output bit full);
    logic [W-1:0] pp = p, cc = c;
    int pl, ps, cl, cs, s, l;
    for (int i = 0; i < 2 * n; i++) begin
      if (!pp[i]) begin pp[i % n] = 1'b0; pp[(i % n) + n] = 1'b0; end
      if (!cc[i]) begin cc[i % n] = 1'b0; cc[(i % n) + n] = 1'b0; end
    end
    longest(pp, n, pl, ps);
    longest(cc, n, cl, cs);
    full = (pl == 2 * n);
    if (full) begin ok = (cl > 0); s = cs; l = cl; end
    else      begin ok = (pl >= 3); s = ps; l = pl; end
    tap = ok ? (((s + s + l - 1) / 2) % n) : 0;
  endfunction

  task automatic run(int n, logic [W-1:0] p, logic [W-1:0] c, string extra);
    bit ok, full, unsup;
    int tap, lat;
    string tg;
    unsup = (n == 0) || (n > MAXT);
    if (!unsup) model(n, p, c, ok, tap, full);
    tg = unsup ? {"R8", extra} : (full ? {"R1 R2 R3", extra} : {"R1 R2 R4", extra});
    @(negedge clk);
    tap_count = CW'(n); pass_mask = p; cmp_mask = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 cleared valid", sel_valid, 0);
    chk("R7 cleared retune", retune_en, 0);
    chk("R7 retune_clr pulse", retune_clr, 1);
    chk("R9 busy", busy, 1);
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk({tg, " R9 latency"}, lat, unsup ? 1 : 2 * n + 1);
    if (unsup) begin
      chk("R8 valid", sel_valid, 0);
      chk("R8 error", sel_error, 0);
      chk("R8 tap kept", sel_tap, prev_tap);
    end else if (ok) begin
      chk({tg, " R7 valid"}, sel_valid, 1);
      chk({tg, " R7 retune_en"}, retune_en, 1);
      chk({tg, " R5 tap"}, sel_tap, tap);
      prev_tap = tap;
    end else begin
      chk({tg, " R6 error"}, sel_error, 1);
      chk({tg, " R6 valid"}, sel_valid, 0);
      chk({tg, " R6 retune_en"}, retune_en, 0);
      chk({tg, " R6 tap kept"}, sel_tap, prev_tap);
    end
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
    chk("R9 busy after done", busy, 0);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 valid", sel_valid, 0);
    chk("R11 error", sel_error, 0);
    chk("R11 retune_en", retune_en, 0);
    chk("R11 retune_clr", retune_clr, 0);
    chk("R11 tap", sel_tap, 0);
    run(0, 8'hFF, 8'hFF, "");
    // Full sweep of pass masks per tap count.
    for (int n = 1; n <= MAXT; n++) begin
      logic [W-1:0] lowm;
      lowm = W'((1 << (2 * n)) - 1);
      for (int m = 0; m < (1 << (2 * n)); m++)
        run(n, W'(m), W'(m ^ 8'h5A) & lowm, "");
    end
    // All pass: compare mask decides.
    for (int n = 1; n <= MAXT; n++) begin
      logic [W-1:0] lowm;
      lowm = W'((1 << (2 * n)) - 1);
      for (int m = 0; m < (1 << (2 * n)); m++)
        run(n, lowm, W'(m), "");
    end
    // Bits above 2N set must not change the outcome.
    for (int n = 1; n < MAXT; n++) begin
      logic [W-1:0] hi;
      hi = ~W'((1 << (2 * n)) - 1);
      for (int m = 0; m < (1 << (2 * n)); m += 3)
        run(n, W'(m) | hi, W'(m ^ 5) | hi, " R10");
      run(n, ~hi, W'(0) | hi, " R10");
    end
    run(5, 8'hFF, 8'hFF, "");
    run(7, 8'h0F, 8'hF0, "");
    summary();
  end
endmodule